// File: doc/BRIEF.md
# Streaming Transmit Packet Ingress Checker

This block sits between user logic and the datapath of a 40 Gb/s Ethernet transmit MAC. User logic presents packets as 128-bit beats (two 64-bit words) with start, end, empty-byte count and error flags. The block returns a ready signal whose meaning is shifted by a fixed ready latency. It checks every beat against that rule, sorts each accepted beat through a three-state packet tracker, and forwards legal beats one cycle later with every byte in its original position. The first packet byte travels in bits 127:120 of the start beat.

The tracker states are `ST_IDLE` (no packet open), `ST_PKT` (a forwarded packet is open) and `ST_SKIP` (discarding beats that arrived without a start). Each transition is driven by an accepted beat. `ST_IDLE` goes to `ST_PKT` on a start without end. It stays in `ST_IDLE` on a start and end in the same beat (rejected) or on a lone end (orphan). It goes to `ST_SKIP` on a beat with neither flag. `ST_PKT` stays in `ST_PKT` on a middle beat or on a new start without end, which is a restart. It goes back to `ST_IDLE` on an end, or on a new start with end in the same beat, which is a restart plus a rejection. `ST_SKIP` goes to `ST_PKT` on a start without end. It goes back to `ST_IDLE` on an end or on a start with end in the same beat. It stays in `ST_SKIP` otherwise.

Every closed or rejected packet produces one status strobe. The strobe carries a 40-bit word and a 7-bit error-type word. The error input arms a corruption mark on the outgoing end beat. The downstream MAC is a plain sink: its `sink_ready` is handed back unchanged as `in_ready`. A sink that raises it in cycle n commits to taking the output beat produced by a transfer in cycle n plus the latency.

Top module: `tx_ingress_chk`

## Requirements
- R1: `in_ready` equals `sink_ready` in every cycle. A valid beat is accepted only in a cycle c for which `in_ready` was high in cycle c minus RDY_LAT (RDY_LAT = 0 means the same cycle). After reset, no cycle is a ready cycle until `in_ready` has been high RDY_LAT cycles earlier.
- R2: A valid beat in a cycle that is not a ready cycle is discarded. It pulses `proto_viol` in the next cycle and produces no output beat and no status.
- R3: An accepted beat that belongs to an open packet, or that starts one without ending it, appears on the outputs exactly one cycle later. `out_data` equals the input bits exactly, and the start, end and empty fields are copied.
- R4: A beat with both start and end is never forwarded. Its status has byte count 16 minus empty in `stat_word[15:0]` and `stat_err[0]` set. `stat_err[1]` is also set when that count is below 9.
- R5: For a forwarded packet of N beats closed by an end beat with empty value E (0 to 15), `stat_word[15:0]` equals 16*N - E, and `stat_word[16]` (forwarded) is 1.
- R6: The error input set on an end beat makes `out_corrupt` high on that output beat, sets `stat_err[3]` and sets `stat_word[17]`. On a non-end beat it has no effect.
- R7: Beats received with no packet open and no start are discarded. The run ends at an end beat or at a start beat. That beat's status has `stat_err[2]` set, byte count 0 and `stat_word[16]` clear.
- R8: A start received while a packet is open raises `out_abort` for one cycle. Status for the old packet is given with its byte count so far, `stat_err[4]`, `stat_word[16]` and `stat_word[17]` set. A start without end is forwarded as the first beat of a new packet.
- R9: `stat_valid` is a one-cycle pulse in the cycle after an accepted beat that carries an end, or a start while the tracker is not in `ST_IDLE`. It is not raised at any other time. `stat_err[6:5]` and `stat_word[39:18]` are always zero.
- R10: While reset is held, `out_valid`, `stat_valid`, `out_abort` and `proto_viol` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sink_ready | input | 1 | Downstream capacity, same latency meaning as `in_ready` |
| in_ready | output | 1 | Ready to user logic, applies RDY_LAT cycles later |
| in_valid | input | 1 | Beat present |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 4 | Unused bytes in the end beat, low end |
| in_err | input | 1 | Corrupt request, sampled on end beats only |
| in_data | input | 128 | Beat data, first byte in bits 127:120 |
| out_valid | output | 1 | Forwarded beat present |
| out_sop | output | 1 | Forwarded start flag |
| out_eop | output | 1 | Forwarded end flag |
| out_empty | output | 4 | Forwarded empty count |
| out_corrupt | output | 1 | Insert an error into this frame |
| out_data | output | 128 | Forwarded data |
| out_abort | output | 1 | Previously open packet terminated in error |
| stat_valid | output | 1 | Status strobe |
| stat_word | output | 40 | [15:0] byte count, [16] forwarded, [17] corrupted |
| stat_err | output | 7 | [0] start+end beat, [1] short, [2] missing start, [3] user error, [4] restart |
| proto_viol | output | 1 | Beat outside a ready cycle was dropped |

## Verification
The assertions assume that `in_valid` and the flags are never X once reset is released. They also assume the sink takes every output beat without a handshake of its own. The bench keeps to this by driving known values on every falling edge and tying the sink to a plain ready level. The checks on data echo and status cause look one cycle back. They rely on the block being fed only on falling edges, so each input is stable across the edge that registers it. The bench raises valid outside a ready cycle only on purpose, in the ready-latency test, and it tracks the ready history it drove itself.

// File: rtl/tx_ingress_pkg.sv
package tx_ingress_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PKT  = 2'd1,
        ST_SKIP = 2'd2
    } trk_state_t;

    localparam int ERR_W      = 7;
    localparam int STAT_W     = 40;
    localparam int EB_SINGLE  = 0;
    localparam int EB_SHORT   = 1;
    localparam int EB_NOSOP   = 2;
    localparam int EB_USER    = 3;
    localparam int EB_RESTART = 4;
endpackage

// File: rtl/tx_ingress_rdy.sv
module tx_ingress_rdy #(
    parameter int RDY_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sink_ready,
    output logic in_ready,
    output logic rdy_cycle
);
    assign in_ready = sink_ready;

    generate
        if (RDY_LAT == 0) begin : g_zero
            assign rdy_cycle = sink_ready;
        end else begin : g_hist
            logic [RDY_LAT-1:0] hist;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist <= '0;
                end else if (RDY_LAT == 1) begin
                    hist <= sink_ready;
                end else begin
                    hist <= {hist, sink_ready};
                end
            end
            assign rdy_cycle = hist[RDY_LAT-1];
        end
    endgenerate
endmodule

// File: rtl/tx_ingress_fsm.sv
module tx_ingress_fsm
    import tx_ingress_pkg::*;
#(
    parameter int BEAT_BYTES = 16,
    parameter int EMPTY_W    = 4,
    parameter int CNT_W      = 16,
    parameter int MIN_BYTES  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  logic               sop,
    input  logic               eop,
    input  logic [EMPTY_W-1:0] empty,
    input  logic               uerr,
    output logic               fwd,
    output logic               fire,
    output logic               abort,
    output logic [CNT_W-1:0]   cnt_out,
    output logic [ERR_W-1:0]   err_out,
    output logic               was_open,
    output logic               corrupt
);
    localparam logic [CNT_W-1:0] BB = CNT_W'(BEAT_BYTES);

    trk_state_t state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W-1:0] last_len;
    logic [CNT_W-1:0] single_len;

    assign last_len   = BB - CNT_W'(empty);
    assign single_len = BB - CNT_W'(empty);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        fwd      = 1'b0;
        fire     = 1'b0;
        abort    = 1'b0;
        cnt_out  = '0;
        err_out  = '0;
        was_open = 1'b0;
        corrupt  = 1'b0;
        if (acc) begin
            fire = eop || (sop && state != ST_IDLE);
            if (sop && eop) begin
                err_out[EB_SINGLE] = 1'b1;
                err_out[EB_SHORT]  = (single_len < CNT_W'(MIN_BYTES));
                cnt_out            = single_len;
            end
            unique case (state)
                ST_IDLE: begin
                    if (sop && !eop) begin
                        state_nx = ST_PKT;
                        cnt_nx   = BB;
                        fwd      = 1'b1;
                    end else if (!sop && eop) begin
                        err_out[EB_NOSOP] = 1'b1;
                    end else if (!sop && !eop) begin
                        state_nx = ST_SKIP;
                    end
                end
                ST_PKT: begin
                    was_open = 1'b1;
                    if (sop) begin
                        abort               = 1'b1;
                        corrupt             = 1'b1;
                        err_out[EB_RESTART] = 1'b1;
                        cnt_out             = cnt;
                        fwd                 = !eop;
                        state_nx            = eop ? ST_IDLE : ST_PKT;
                        cnt_nx              = BB;
                    end else if (eop) begin
                        fwd              = 1'b1;
                        cnt_out          = cnt + last_len;
                        err_out[EB_USER] = uerr;
                        corrupt          = uerr;
                        state_nx         = ST_IDLE;
                    end else begin
                        fwd    = 1'b1;
                        cnt_nx = cnt + BB;
                    end
                end
                ST_SKIP: begin
                    if (sop || eop) begin
                        err_out[EB_NOSOP] = 1'b1;
                        if (sop && !eop) begin
                            cnt_out = '0;
                        end
                    end
                    if (sop && !eop) begin
                        state_nx = ST_PKT;
                        cnt_nx   = BB;
                        fwd      = 1'b1;
                    end else if (eop) begin
                        state_nx = ST_IDLE;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tx_ingress_chk.sv
module tx_ingress_chk
    import tx_ingress_pkg::*;
#(
    parameter int DATA_W    = 128,
    parameter int RDY_LAT   = 2,
    parameter int CNT_W     = 16,
    parameter int MIN_BYTES = 9,
    localparam int BEAT_BYTES = DATA_W / 8,
    localparam int EMPTY_W    = $clog2(BEAT_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sink_ready,
    output logic               in_ready,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [EMPTY_W-1:0] in_empty,
    input  logic               in_err,
    input  logic [DATA_W-1:0]  in_data,
    output logic               out_valid,
    output logic               out_sop,
    output logic               out_eop,
    output logic [EMPTY_W-1:0] out_empty,
    output logic               out_corrupt,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_abort,
    output logic               stat_valid,
    output logic [STAT_W-1:0]  stat_word,
    output logic [ERR_W-1:0]   stat_err,
    output logic               proto_viol
);
    localparam int PAD_W = STAT_W - CNT_W - 2;

    logic             rdy_cycle;
    logic             acc;
    logic             fwd, fire, abort, was_open, corrupt;
    logic [CNT_W-1:0] cnt_out;
    logic [ERR_W-1:0] err_out;

    tx_ingress_rdy #(.RDY_LAT(RDY_LAT)) rdy_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sink_ready(sink_ready),
        .in_ready  (in_ready),
        .rdy_cycle (rdy_cycle)
    );

    assign acc = in_valid && rdy_cycle;

    tx_ingress_fsm #(
        .BEAT_BYTES(BEAT_BYTES),
        .EMPTY_W   (EMPTY_W),
        .CNT_W     (CNT_W),
        .MIN_BYTES (MIN_BYTES)
    ) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (acc),
        .sop     (in_sop),
        .eop     (in_eop),
        .empty   (in_empty),
        .uerr    (in_err),
        .fwd     (fwd),
        .fire    (fire),
        .abort   (abort),
        .cnt_out (cnt_out),
        .err_out (err_out),
        .was_open(was_open),
        .corrupt (corrupt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_sop     <= 1'b0;
            out_eop     <= 1'b0;
            out_empty   <= '0;
            out_corrupt <= 1'b0;
            out_data    <= '0;
            out_abort   <= 1'b0;
            stat_valid  <= 1'b0;
            stat_word   <= '0;
            stat_err    <= '0;
            proto_viol  <= 1'b0;
        end else begin
            out_valid  <= fwd;
            out_abort  <= abort;
            stat_valid <= fire;
            proto_viol <= in_valid && !rdy_cycle;
            if (fwd) begin
                out_sop     <= in_sop;
                out_eop     <= in_eop;
                out_empty   <= in_empty;
                out_corrupt <= in_eop && in_err;
                out_data    <= in_data;
            end
            if (fire) begin
                stat_word <= {{PAD_W{1'b0}}, corrupt, was_open, cnt_out};
                stat_err  <= err_out;
            end
        end
    end
endmodule

// File: rtl/tx_ingress_chk_sva.sv
module tx_ingress_chk_sva #(
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sop,
    input logic              in_eop,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_sop,
    input logic              out_eop,
    input logic              out_corrupt,
    input logic [DATA_W-1:0] out_data,
    input logic              out_abort,
    input logic              stat_valid,
    input logic [6:0]        stat_err,
    input logic              proto_viol
);
    a_r3_data_echo: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == $past(in_data) && $past(in_valid)));

    a_r4_no_single_beat_out: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sop && out_eop));

    a_r2_viol_silent: assert property (@(posedge clk) disable iff (!rst_n)
        proto_viol |-> (!out_valid && !stat_valid));

    a_r8_abort_status: assert property (@(posedge clk) disable iff (!rst_n)
        out_abort |-> (stat_valid && stat_err[4]));

    a_r9_status_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(in_valid && (in_sop || in_eop)));

    a_r6_corrupt_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_corrupt) |-> out_eop);
endmodule

bind tx_ingress_chk tx_ingress_chk_sva #(.DATA_W(DATA_W)) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_corrupt(out_corrupt),
    .out_data   (out_data),
    .out_abort  (out_abort),
    .stat_valid (stat_valid),
    .stat_err   (stat_err),
    .proto_viol (proto_viol)
);

// File: tb/tx_ingress_chk_tb_top.sv
`timescale 1ns/1ps
module tx_ingress_chk_tb_top;
    localparam int RL = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sink_ready = 1'b0;
    logic         in_ready;
    logic         in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
    logic [3:0]   in_empty = '0;
    logic [127:0] in_data = '0;
    logic         out_valid, out_sop, out_eop, out_corrupt, out_abort;
    logic [3:0]   out_empty;
    logic [127:0] out_data;
    logic         stat_valid, proto_viol;
    logic [39:0]  stat_word;
    logic [6:0]   stat_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tx_ingress_chk #(.RDY_LAT(RL)) dut_i (
        .clk(clk), .rst_n(rst_n), .sink_ready(sink_ready), .in_ready(in_ready),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
        .in_err(in_err), .in_data(in_data), .out_valid(out_valid), .out_sop(out_sop),
        .out_eop(out_eop), .out_empty(out_empty), .out_corrupt(out_corrupt),
        .out_data(out_data), .out_abort(out_abort), .stat_valid(stat_valid),
        .stat_word(stat_word), .stat_err(stat_err), .proto_viol(proto_viol)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic beat(input logic v, input logic s, input logic e,
                        input logic [3:0] em, input logic er, input logic [127:0] d);
        in_valid = v; in_sop = s; in_eop = e; in_empty = em; in_err = er; in_data = d;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic stat_chk(input string req, input logic v, input logic [39:0] w,
                            input logic [6:0] er);
        chk({req, " stat_valid"}, 128'(stat_valid), 128'(v));
        if (v) begin
            chk({req, " stat_word"}, 128'(stat_word), 128'(w));
            chk({req, " stat_err"}, 128'(stat_err), 128'(er));
        end
    endtask

    function automatic logic [127:0] mk(input int pid, input int b);
        return {8{pid[7:0], b[7:0]}};
    endfunction

    function automatic logic [39:0] sw(input logic crp, input logic fw, input int n);
        return {22'd0, crp, fw, n[15:0]};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int pid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 out_valid", 128'(out_valid), 128'(0));
        chk("R10 stat_valid", 128'(stat_valid), 128'(0));
        chk("R10 out_abort", 128'(out_abort), 128'(0));
        chk("R10 proto_viol", 128'(proto_viol), 128'(0));
        rst_n = 1'b1;
        sink_ready = 1'b1;
        chk("R1 ready mirrors sink", 128'(in_ready), 128'(1));
        for (int i = 0; i <= RL; i++) beat(0, 0, 0, 0, 0, '0);

        // R3 R5 R6: sweep beats x empty x error
        for (int nb = 2; nb <= 4; nb++)
            for (int e = 0; e < 16; e++)
                for (int er = 0; er < 2; er++) begin
                    pid++;
                    for (int b = 0; b < nb; b++) begin
                        logic last;
                        last = (b == nb - 1);
                        beat(1, b == 0, last, last ? 4'(e) : 4'(0), last ? er[0] : 1'b1, mk(pid, b));
                        chk("R3 out_valid", 128'(out_valid), 128'(1));
                        chk("R3 out_data", out_data, mk(pid, b));
                        chk("R3 out_sop", 128'(out_sop), 128'(b == 0));
                        chk("R3 out_eop", 128'(out_eop), 128'(last));
                        chk("R6 out_corrupt", 128'(out_corrupt), 128'(last && er[0]));
                        if (last) begin
                            chk("R3 out_empty", 128'(out_empty), 128'(e));
                            stat_chk("R5", 1, sw(er[0], 1, 16 * nb - e), er[0] ? 7'h08 : 7'h00);
                        end else begin
                            stat_chk("R9", 0, '0, '0);
                        end
                    end
                end

        // R4 single beat packets over every empty value
        for (int e = 0; e < 16; e++) begin
            beat(1, 1, 1, 4'(e), 0, mk(200, e));
            chk("R4 not forwarded", 128'(out_valid), 128'(0));
            stat_chk("R4", 1, sw(0, 0, 16 - e), (e > 7) ? 7'h03 : 7'h01);
        end

        // R7 orphan beats
        beat(1, 0, 0, 0, 0, mk(1, 1));
        chk("R7 orphan dropped", 128'(out_valid), 128'(0));
        stat_chk("R7 mid", 0, '0, '0);
        beat(1, 0, 0, 0, 0, mk(1, 2));
        beat(1, 0, 1, 3, 1, mk(1, 3));
        chk("R7 orphan end dropped", 128'(out_valid), 128'(0));
        stat_chk("R7 end", 1, sw(0, 0, 0), 7'h04);
        beat(1, 0, 0, 0, 0, mk(2, 1));
        beat(1, 1, 0, 0, 0, mk(2, 2));
        chk("R7 start after run", 128'(out_valid), 128'(1));
        stat_chk("R7 run closed by start", 1, sw(0, 0, 0), 7'h04);
        beat(1, 0, 1, 0, 0, mk(2, 3));
        stat_chk("R7 new packet end", 1, sw(0, 1, 32), 7'h00);

        // R8 restart while open
        beat(1, 1, 0, 0, 0, mk(3, 0));
        beat(1, 0, 0, 0, 0, mk(3, 1));
        beat(1, 1, 0, 0, 0, mk(3, 2));
        chk("R8 out_abort", 128'(out_abort), 128'(1));
        chk("R8 new start forwarded", 128'(out_valid && out_sop), 128'(1));
        stat_chk("R8 old packet", 1, sw(1, 1, 32), 7'h10);
        beat(1, 0, 1, 5, 0, mk(3, 3));
        chk("R8 abort one cycle", 128'(out_abort), 128'(0));
        stat_chk("R8 new packet", 1, sw(0, 1, 27), 7'h00);
        beat(1, 1, 0, 0, 0, mk(4, 0));
        beat(1, 1, 1, 10, 0, mk(4, 1));
        chk("R8 abort with single", 128'(out_abort), 128'(1));
        chk("R8 single not forwarded", 128'(out_valid), 128'(0));
        stat_chk("R8 merged", 1, sw(1, 1, 16), 7'h13);
        beat(1, 0, 1, 0, 0, mk(4, 2));
        stat_chk("R8 idle after merge", 1, sw(0, 0, 0), 7'h04);

        // R1 R2 ready latency
        sink_ready = 1'b0;
        for (int i = 0; i <= RL; i++) beat(0, 0, 0, 0, 0, '0);
        chk("R1 ready low", 128'(in_ready), 128'(0));
        for (int j = 0; j <= RL; j++) begin
            if (j == 0) sink_ready = 1'b1;
            beat(1, 1, 0, 0, 0, mk(5, j));
            if (j < RL) begin
                chk("R2 proto_viol", 128'(proto_viol), 128'(1));
                chk("R2 dropped", 128'(out_valid), 128'(0));
                stat_chk("R2 no status", 0, '0, '0);
            end else begin
                chk("R1 accepted at latency", 128'(proto_viol), 128'(0));
                chk("R1 beat out", 128'(out_valid && out_sop), 128'(1));
                chk("R1 data", out_data, mk(5, j));
            end
        end
        beat(1, 0, 1, 0, 0, mk(5, 9));
        stat_chk("R1 packet closes", 1, sw(0, 1, 32), 7'h00);
        beat(0, 0, 0, 0, 0, '0);
        chk("R9 pulse one cycle", 128'(stat_valid), 128'(0));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule